// File: doc/BRIEF.md
# Receive-Scaling Key and Steering Table Programmer

This block is the register side of a receive-side-scaling unit in an Ethernet MAC. Software uses it to load a 320-bit hash key and a 256-entry steering table, and to set which traffic classes get hashed. The hash engine and the receive path sit next to it. The engine reads the key straight off a wide output. It turns a packet hash into an 8-bit index and feeds that index to a lookup port, which returns the receive DMA channel stored in that table entry.

Software never writes the key or the table directly. It first writes a 32-bit value into a staging data register. It then writes the command register with the entry index, a store-select bit and a start bit. The start bit stays set as a busy flag for a fixed number of cycles, and the block commits the value at the moment the flag clears. Software polls the flag before it starts the next operation.

A separate control register holds a global enable and three protocol enables. A read-only capability word reports that the feature is present. The lookup port is a plain combinational path with no handshake and no back-pressure. A result is offered whenever an index is applied, and its valid flag follows the global enable. The register bus is also plain: a write strobe with address and data, and a read data bus that follows the address within the same cycle.

Top module: `rss_indirect_prog`

## Requirements
- R1: After reset, the control, command and data registers read zero, the busy flag is clear, every key word and every table entry is zero, and `lkp_valid` is low.
- R2: The control register at offset 0xC80 holds bit 0 (global enable), bit 1 (IP 2-tuple hashing), bit 2 (IPv4 TCP hashing) and bit 3 (IPv4 UDP hashing). It reads these back with all other bits zero and drives `lkp_valid`, `hash_en_ip2`, `hash_en_tcp4` and `hash_en_udp4` from bits 0 to 3 respectively.
- R3: The capability word at offset 0x120 reads with bit 20 set and every other bit zero.
- R4: A write to the command register at offset 0xC88 with bit 0 set, made while not busy, starts an operation. Bit 0 of that register then reads 1 in the next cycle and reads 0 again exactly OP_LAT cycles (default 4) after the write. The register also reads back the index in bits 17:8 and the store select in bit 2.
- R5: An operation with bit 2 set and index 0 to 9 stores the data register into key word `idx`, which appears on `hash_key[32*idx+31:32*idx]`. The key does not change while busy stays set.
- R6: An operation with bit 2 clear and index 0 to 255 stores bits 7:0 of the data register into table entry `idx`.
- R7: An operation whose index lies beyond the selected store (above 9 for the key, above 255 for the table) runs through busy normally and changes no key word and no table entry.
- R8: While busy is set, writes to the command register and to the data register at 0xC8C are ignored. The readback values stay the same and the operation in flight commits its original value to its original entry.
- R9: Clearing bit 0 of the control register drives `lkp_valid` low from the next cycle and leaves the key and table contents unchanged.
- R10: The data register reads back the last value accepted. A command write with bit 0 clear updates the index and select readback without starting an operation or changing storage.
- R11: `lkp_chan` returns the table entry addressed by `lkp_idx` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| lkp_idx | input | 8 | Hash index to look up |
| lkp_chan | output | 8 | DMA channel stored in the indexed entry |
| lkp_valid | output | 1 | Global enable, qualifies `lkp_chan` |
| hash_en_ip2 | output | 1 | IP 2-tuple hashing enabled |
| hash_en_tcp4 | output | 1 | IPv4 TCP hashing enabled |
| hash_en_udp4 | output | 1 | IPv4 UDP hashing enabled |
| hash_key | output | 320 | Hash key, word 0 in the low bits |

## Verification
The assertions assume that the register bus issues at most one write per cycle. They also assume that a busy flag can only have been set by a command write that carried the start bit, so the bus must not drive unknown values on `reg_addr` or `reg_wdata` while `reg_wr` is high. The bench keeps to this rule. It drives every bus field from tasks on the falling edge and returns `reg_wr` to zero after each write. It starts a new operation only after the busy flag has been seen clear. The one exception is the R8 test, which writes into a busy window on purpose to show that those writes are dropped.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 12;
  localparam int IDX_FLD_W = 10;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'hC80;
  localparam logic [ADDR_W-1:0] OFF_CMD  = 12'hC88;
  localparam logic [ADDR_W-1:0] OFF_DATA = 12'hC8C;
  localparam logic [ADDR_W-1:0] OFF_CAP  = 12'h120;

  localparam int CTL_EN   = 0;
  localparam int CTL_IP2  = 1;
  localparam int CTL_TCP4 = 2;
  localparam int CTL_UDP4 = 3;

  localparam int CMD_GO   = 0;
  localparam int CMD_KSEL = 2;
  localparam int CMD_IDX  = 8;

  localparam int CAP_BIT  = 20;

  typedef struct packed {
    logic                 ksel;
    logic [IDX_FLD_W-1:0] idx;
  } target_t;
endpackage

// File: rtl/rss_csr.sv
module rss_csr
  import rss_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [3:0]        ctl_q,
  output target_t           tgt_q,
  output logic [REG_W-1:0]  data_q,
  output logic              launch
);
  logic wr_ctl, wr_cmd, wr_dat;

  always_comb begin
    wr_ctl = reg_wr && (reg_addr == OFF_CTRL);
    wr_cmd = reg_wr && (reg_addr == OFF_CMD) && !busy;
    wr_dat = reg_wr && (reg_addr == OFF_DATA) && !busy;
    launch = wr_cmd && reg_wdata[CMD_GO];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      tgt_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= reg_wdata[3:0];
      if (wr_cmd) begin
        tgt_q.ksel <= reg_wdata[CMD_KSEL];
        tgt_q.idx  <= reg_wdata[CMD_IDX +: IDX_FLD_W];
      end
      if (wr_dat) data_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFF_CTRL: reg_rdata[3:0] = ctl_q;
      OFF_CMD: begin
        reg_rdata[CMD_IDX +: IDX_FLD_W] = tgt_q.idx;
        reg_rdata[CMD_KSEL]             = tgt_q.ksel;
        reg_rdata[CMD_GO]               = busy;
      end
      OFF_DATA: reg_rdata = data_q;
      OFF_CAP:  reg_rdata[CAP_BIT] = 1'b1;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rss_seq.sv
module rss_seq #(
  parameter int OP_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic commit
);
  localparam int CNT_W = $clog2(OP_LAT + 1);

  logic [CNT_W-1:0] cnt;

  always_comb commit = busy && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(OP_LAT);
    end else if (busy) begin
      if (commit) busy <= 1'b0;
      cnt <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rss_store.sv
module rss_store
  import rss_pkg::*;
#(
  parameter int KEY_WORDS = 10,
  parameter int TBL_DEPTH = 256,
  parameter int CHAN_W    = 8,
  localparam int TIDX_W   = $clog2(TBL_DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit,
  input  target_t                    tgt,
  input  logic [REG_W-1:0]           data,
  input  logic [TIDX_W-1:0]          lkp_idx,
  output logic [CHAN_W-1:0]          lkp_chan,
  output logic [KEY_WORDS*REG_W-1:0] key_flat
);
  logic [CHAN_W-1:0] tbl [TBL_DEPTH];

  for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
    logic hit;
    always_comb hit = commit && tgt.ksel && (tgt.idx == IDX_FLD_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)   key_flat[k*REG_W +: REG_W] <= '0;
      else if (hit) key_flat[k*REG_W +: REG_W] <= data;
    end
  end

  for (genvar t = 0; t < TBL_DEPTH; t++) begin : g_tbl
    logic hit;
    always_comb hit = commit && !tgt.ksel && (tgt.idx == IDX_FLD_W'(t));
    always_ff @(posedge clk) begin
      if (!rst_n)   tbl[t] <= '0;
      else if (hit) tbl[t] <= data[CHAN_W-1:0];
    end
  end

  always_comb lkp_chan = tbl[lkp_idx];
endmodule

// File: rtl/rss_indirect_prog.sv
module rss_indirect_prog
  import rss_pkg::*;
#(
  parameter int OP_LAT    = 4,
  parameter int KEY_WORDS = 10,
  parameter int TBL_DEPTH = 256,
  parameter int CHAN_W    = 8,
  localparam int TIDX_W   = $clog2(TBL_DEPTH),
  localparam int KEY_W    = KEY_WORDS * REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [TIDX_W-1:0] lkp_idx,
  output logic [CHAN_W-1:0] lkp_chan,
  output logic              lkp_valid,
  output logic              hash_en_ip2,
  output logic              hash_en_tcp4,
  output logic              hash_en_udp4,
  output logic [KEY_W-1:0]  hash_key
);
  logic [3:0]       ctl_q;
  target_t          tgt_q;
  logic [REG_W-1:0] data_q;
  logic             launch, busy, commit;

  rss_csr u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .reg_rdata(reg_rdata),
    .ctl_q(ctl_q), .tgt_q(tgt_q), .data_q(data_q), .launch(launch)
  );

  rss_seq #(.OP_LAT(OP_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .commit(commit)
  );

  rss_store #(.KEY_WORDS(KEY_WORDS), .TBL_DEPTH(TBL_DEPTH), .CHAN_W(CHAN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .tgt(tgt_q), .data(data_q),
    .lkp_idx(lkp_idx), .lkp_chan(lkp_chan), .key_flat(hash_key)
  );

  always_comb begin
    lkp_valid    = ctl_q[CTL_EN];
    hash_en_ip2  = ctl_q[CTL_IP2];
    hash_en_tcp4 = ctl_q[CTL_TCP4];
    hash_en_udp4 = ctl_q[CTL_UDP4];
  end
endmodule

// File: rtl/rss_indirect_prog_chk.sv
module rss_indirect_prog_chk
  import rss_pkg::*;
#(
  parameter int OP_LAT = 4,
  parameter int KEY_W  = 320
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              busy,
  input logic [REG_W-1:0]  data_q,
  input logic [KEY_W-1:0]  hash_key,
  input logic              lkp_valid
);
  logic [15:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 16'd1;
    else           run_cnt <= '0;
  end

  // R4
  busy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == OFF_CMD && reg_wdata[CMD_GO]));

  // R4
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 16'(OP_LAT));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == OFF_DATA) |=> $stable(data_q));

  // R5
  key_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy -> $stable(hash_key)));

  // R9
  disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_CTRL && !reg_wdata[CTL_EN]) |=> !lkp_valid);
endmodule

bind rss_indirect_prog rss_indirect_prog_chk #(.OP_LAT(OP_LAT), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .data_q(data_q),
  .hash_key(hash_key), .lkp_valid(lkp_valid)
);

// File: tb/tb_rss_indirect_prog.sv
module tb_rss_indirect_prog;
  localparam int CLK_PERIOD = 10;
  localparam int OP_LAT     = 4;
  localparam logic [11:0] A_CTRL = 12'hC80;
  localparam logic [11:0] A_CMD  = 12'hC88;
  localparam logic [11:0] A_DATA = 12'hC8C;
  localparam logic [11:0] A_CAP  = 12'h120;

  // {ksel, idx[9:0], data[31:0]}
  localparam int NVEC = 7;
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b1, 10'd0,   32'hA5A5_0001},
    {1'b1, 10'd9,   32'h1234_5678},
    {1'b1, 10'd5,   32'hDEAD_BEEF},
    {1'b0, 10'd0,   32'h0000_0003},
    {1'b0, 10'd255, 32'hFFFF_FF07},
    {1'b0, 10'd17,  32'h0000_0042},
    {1'b0, 10'd128, 32'h1234_56C1}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [7:0]  lkp_idx = 0;
  logic [7:0]  lkp_chan;
  logic        lkp_valid, hash_en_ip2, hash_en_tcp4, hash_en_udp4;
  logic [319:0] hash_key;

  int checks = 0;
  int errors = 0;
  logic done = 0;

  rss_indirect_prog dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lkp_idx(lkp_idx),
    .lkp_chan(lkp_chan), .lkp_valid(lkp_valid), .hash_en_ip2(hash_en_ip2),
    .hash_en_tcp4(hash_en_tcp4), .hash_en_udp4(hash_en_udp4), .hash_key(hash_key)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 1;
    reg_addr = A_CMD;
    #1;
    while (reg_rdata[0] && n < 100) begin
      @(negedge clk);
      #1;
      if (reg_rdata[0]) n++;
    end
  endtask

  task automatic run_op(input logic ks, input logic [9:0] idx, input logic [31:0] d, output int n);
    bus_wr(A_DATA, d);
    bus_wr(A_CMD, {12'd0, idx, 5'd0, ks, 2'b01});
    wait_idle(n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [319:0] key_snap;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(A_CTRL, r); check("R1 ctrl", r, 0);
    bus_rd(A_CMD, r);  check("R1 cmd", r, 0);
    bus_rd(A_DATA, r); check("R1 data", r, 0);
    check("R1 valid", {31'd0, lkp_valid}, 0);
    check("R1 key", {31'd0, |hash_key}, 0);
    lkp_idx = 8'd200; #1 check("R1 table", {24'd0, lkp_chan}, 0);

    // R3 capability
    bus_rd(A_CAP, r); check("R3 cap", r, 32'h0010_0000);

    // R2 control
    bus_wr(A_CTRL, 32'hFFFF_FFFF);
    bus_rd(A_CTRL, r); check("R2 readback", r, 32'hF);
    check("R2 pins", {28'd0, hash_en_udp4, hash_en_tcp4, hash_en_ip2, lkp_valid}, 32'hF);
    bus_wr(A_CTRL, 32'h5);
    check("R2 pins b", {28'd0, hash_en_udp4, hash_en_tcp4, hash_en_ip2, lkp_valid}, 32'h5);

    // R4 R5 R6 R11 vector walk
    for (int i = 0; i < NVEC; i++) begin
      logic ks; logic [9:0] idx; logic [31:0] d;
      {ks, idx, d} = VEC[i];
      run_op(ks, idx, d, n);
      check("R4 busy cycles", n, OP_LAT);
      bus_rd(A_CMD, r); check("R4 cmd readback", r, {12'd0, idx, 5'd0, ks, 2'b00});
      bus_rd(A_DATA, r); check("R10 data readback", r, d);
      if (ks) check("R5 key word", hash_key[32*idx +: 32], d);
      else begin
        lkp_idx = idx[7:0]; #1;
        check("R6 R11 table entry", {24'd0, lkp_chan}, {24'd0, d[7:0]});
      end
    end

    // R7 out of range
    key_snap = hash_key;
    run_op(1'b1, 10'd10, 32'hCAFE_F00D, n);
    check("R7 key busy", n, OP_LAT);
    check("R7 key intact", {31'd0, hash_key == key_snap}, 1);
    run_op(1'b0, 10'd256, 32'h0000_0099, n);
    lkp_idx = 8'd0; #1 check("R7 table entry 0", {24'd0, lkp_chan}, 32'h03);
    run_op(1'b0, 10'd511, 32'h0000_00EE, n);
    lkp_idx = 8'd255; #1 check("R7 table entry 255", {24'd0, lkp_chan}, 32'h07);

    // R8 writes ignored while busy
    bus_wr(A_DATA, 32'h0000_0055);
    bus_wr(A_CMD, {12'd0, 10'd40, 8'b0000_0001});
    bus_wr(A_DATA, 32'h0000_00AA);
    bus_wr(A_CMD, {12'd0, 10'd41, 8'b0000_0101});
    wait_idle(n);
    bus_rd(A_DATA, r); check("R8 data kept", r, 32'h55);
    bus_rd(A_CMD, r);  check("R8 cmd kept", r, {12'd0, 10'd40, 8'd0});
    lkp_idx = 8'd40; #1 check("R8 entry 40", {24'd0, lkp_chan}, 32'h55);
    lkp_idx = 8'd41; #1 check("R8 entry 41", {24'd0, lkp_chan}, 32'h00);

    // R10 command without start bit
    bus_wr(A_DATA, 32'h0000_0033);
    bus_wr(A_CMD, {12'd0, 10'd17, 8'b0000_0000});
    bus_rd(A_CMD, r); check("R10 no-go readback", r, {12'd0, 10'd17, 8'd0});
    repeat (OP_LAT + 1) @(negedge clk);
    lkp_idx = 8'd17; #1 check("R10 entry unchanged", {24'd0, lkp_chan}, 32'h42);

    // R9 disable keeps contents
    key_snap = hash_key;
    bus_wr(A_CTRL, 32'h4);
    check("R9 valid low", {31'd0, lkp_valid}, 0);
    check("R9 tcp4 kept", {31'd0, hash_en_tcp4}, 1);
    check("R9 key intact", {31'd0, hash_key == key_snap}, 1);
    lkp_idx = 8'd128; #1 check("R9 table intact", {24'd0, lkp_chan}, 32'hC1);
    bus_wr(A_CTRL, 32'h1);
    check("R9 valid back", {31'd0, lkp_valid}, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule